// File: doc/BRIEF.md
# Serial Ferroelectric RAM Target Model

This block is the target end of an SPI link to a small nonvolatile byte store. It watches the serial clock, chip-select and data-in pins, using its own system clock to sample them. Each transaction starts when chip-select goes low. The first byte is an opcode. Depending on the opcode, an address and data bytes follow. The block holds a byte array and a status register. It answers status reads, data reads and identification reads on its serial output. Writes land at once, and the part never reports busy.

Stores are guarded in two ways. A write-enable latch must be armed before each write or status write, and it drops when that command ends. Block-protect bits in the status register fence off an upper fraction of the array. A protect flag, together with a dedicated write-protect pin, can lock the status register. The identification read returns a run of continuation bytes, then a memory-type byte, then a capacity code and a part code taken from parameters.

Top module: `fram_spi_slave`

## Requirements
- R1: After reset, every status bit is 0, every array byte reads 0, and the serial output is 0 while chip-select is high.
- R2: Opcode 0x06 sets the write-enable latch (status bit 1) and opcode 0x04 clears it.
- R3: After opcode 0x05, every following byte slot returns the status byte {protect-lock bit 7, 0, 0, protect code in bits 4:2, latch bit 1, 0}; bit 0 is always 0.
- R4: Opcode 0x03 (read) and opcode 0x02 (write) take an address of ADDR_BYTES bytes, most significant byte first. Data then moves at consecutive addresses for as long as the clock runs, and the address wraps to 0 after the last byte of the array.
- R5: A write or status write issued while the latch is clear changes nothing.
- R6: The latch clears when chip-select rises at the end of a write (0x02) or status-write (0x01) command.
- R7: A protect code c makes the following addresses read-only: none for c=0, the whole array for c=7, and otherwise the top MEM_BYTES>>(7-c) bytes. A data byte aimed at a read-only address is dropped, and the address still advances.
- R8: Opcode 0x01 loads only status bits 7 and 4:2 from its first data byte.
- R9: Opcode 0x01 is refused while status bit 7 is 1 and spi_wp_n is low.
- R10: Opcode 0x9F returns six 0x7F bytes, then 0xC2, then CAP_CODE, then PART_CODE.
- R11: An opcode outside the supported set holds the output at 0 and ignores all bytes until chip-select rises.
- R12: Serial mode 3 is used. Output bits change only after a falling clock edge and hold steady while the clock is high, with bit 7 first.
- R13: Chip-select rising drops any partial byte, so the next byte after chip-select falls is treated as an opcode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock, idle high |
| spi_cs_n | input | 1 | Active-low chip-select |
| spi_mosi | input | 1 | Serial data into the block |
| spi_wp_n | input | 1 | Active-low write-protect pin for the status register |
| spi_miso | output | 1 | Serial data out of the block, 0 when idle |

## Verification
The bench sweeps every protect code and writes across the boundary of each guarded region. A wrong boundary decode would corrupt a guarded byte or drop a legal one. Writing a single burst through the top of the array exposes two faults: an address that fails to wrap, and one that freezes on a dropped byte. The bench probes the latch after each write command and the status lock with the write-protect pin both low and high. A latch that stays set would let a second, unarmed write land. A lock that ignores the pin would either freeze the status for good or never hold it. The identification stream, unknown opcodes and a truncated byte are also checked. A model that misframes after chip-select rises would take the next opcode as data.

// File: rtl/fram_spi_slave.sv
module fram_spi_slave #(
  parameter int MEM_BYTES = 256,
  parameter int ADDR_BYTES = 2,
  parameter logic [7:0] CAP_CODE = 8'h21,
  parameter logic [7:0] PART_CODE = 8'h08
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  input  logic spi_wp_n,
  output logic spi_miso
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_ID = 8'h9F;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_WDAT, ST_RDAT, ST_STAT, ST_SWR, ST_ID, ST_SKIP
  } state_t;

  logic [1:0] sck_m, cs_m, mosi_m, wp_m;
  logic sck_q, cs_q;
  logic sck_s, cs_s, mosi_s, wp_s;
  logic rise, fall, cs_rise, byte_done;
  logic [7:0] rx_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 2'b11;
      cs_m <= 2'b11;
      mosi_m <= 2'b00;
      wp_m <= 2'b11;
      sck_q <= 1'b1;
      cs_q <= 1'b1;
    end else begin
      sck_m <= {sck_m[0], spi_sck};
      cs_m <= {cs_m[0], spi_cs_n};
      mosi_m <= {mosi_m[0], spi_mosi};
      wp_m <= {wp_m[0], spi_wp_n};
      sck_q <= sck_m[1];
      cs_q <= cs_m[1];
    end
  end

  assign sck_s = sck_m[1];
  assign cs_s = cs_m[1];
  assign mosi_s = mosi_m[1];
  assign wp_s = wp_m[1];
  assign rise = sck_s & ~sck_q & ~cs_s;
  assign fall = ~sck_s & sck_q & ~cs_s;
  assign cs_rise = cs_s & ~cs_q;

  state_t state;
  logic [2:0] bitcnt;
  logic [6:0] shreg;
  logic [1:0] acnt;
  logic [ADDR_W-1:0] addr;
  logic [3:0] idcnt;
  logic [7:0] txreg;
  logic rd_cmd, wr_cmd;
  logic wel, srwd;
  logic [2:0] bp;
  logic [7:0] mem [MEM_BYTES];
  logic [7:0] status_byte;
  logic [ADDR_W-1:0] addr_in;
  logic skip_st, data_adv;

  assign byte_done = rise && (bitcnt == 3'd7);
  assign rx_byte = {shreg, mosi_s};
  assign status_byte = {srwd, 2'b00, bp, wel, 1'b0};
  assign addr_in = ADDR_W'({addr, rx_byte});
  assign skip_st = (state == ST_SKIP);
  assign data_adv = byte_done && (state == ST_RDAT || state == ST_WDAT);

  function automatic logic guarded(input logic [2:0] code, input logic [ADDR_W-1:0] a);
    int lim;
    if (code == 3'd0) return 1'b0;
    if (code == 3'd7) return 1'b1;
    lim = MEM_BYTES - (MEM_BYTES >> (7 - int'(code)));
    return {{(32-ADDR_W){1'b0}}, a} >= 32'(lim);
  endfunction

  function automatic logic [7:0] id_byte(input logic [3:0] n);
    if (n < 4'd6) return 8'h7F;
    case (n)
      4'd6: return 8'hC2;
      4'd7: return CAP_CODE;
      4'd8: return PART_CODE;
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_OPC;
      bitcnt <= '0;
      shreg <= '0;
      acnt <= '0;
      addr <= '0;
      idcnt <= '0;
      txreg <= '0;
      rd_cmd <= 1'b0;
      wr_cmd <= 1'b0;
      wel <= 1'b0;
      srwd <= 1'b0;
      bp <= '0;
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
    end else if (cs_s) begin
      state <= ST_OPC;
      bitcnt <= '0;
      txreg <= '0;
      rd_cmd <= 1'b0;
      wr_cmd <= 1'b0;
      if (cs_rise && wr_cmd) wel <= 1'b0;
    end else if (rise) begin
      bitcnt <= bitcnt + 3'd1;
      shreg <= rx_byte[6:0];
      if (byte_done) begin
        txreg <= '0;
        case (state)
          ST_OPC: begin
            case (rx_byte)
              OP_WREN: begin wel <= 1'b1; state <= ST_SKIP; end
              OP_WRDI: begin wel <= 1'b0; state <= ST_SKIP; end
              OP_RDSR: begin txreg <= status_byte; state <= ST_STAT; end
              OP_WRSR: begin wr_cmd <= 1'b1; state <= ST_SWR; end
              OP_READ: begin rd_cmd <= 1'b1; acnt <= '0; state <= ST_ADDR; end
              OP_WRITE: begin wr_cmd <= 1'b1; acnt <= '0; state <= ST_ADDR; end
              OP_ID: begin txreg <= 8'h7F; idcnt <= 4'd1; state <= ST_ID; end
              default: state <= ST_SKIP;
            endcase
          end
          ST_ADDR: begin
            acnt <= acnt + 2'd1;
            if (int'(acnt) == ADDR_BYTES - 1) begin
              if (rd_cmd) begin
                txreg <= mem[addr_in];
                addr <= addr_in + 1'b1;
                state <= ST_RDAT;
              end else begin
                addr <= addr_in;
                state <= ST_WDAT;
              end
            end else begin
              addr <= addr_in;
            end
          end
          ST_RDAT: begin
            txreg <= mem[addr];
            addr <= addr + 1'b1;
          end
          ST_WDAT: begin
            if (wel && !guarded(bp, addr)) mem[addr] <= rx_byte;
            addr <= addr + 1'b1;
          end
          ST_STAT: txreg <= status_byte;
          ST_SWR: begin
            if (wel && !(srwd && !wp_s)) begin
              srwd <= rx_byte[7];
              bp <= rx_byte[4:2];
            end
            state <= ST_SKIP;
          end
          ST_ID: begin
            txreg <= id_byte(idcnt);
            if (idcnt != 4'd9) idcnt <= idcnt + 4'd1;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) spi_miso <= 1'b0;
    else if (cs_s) spi_miso <= 1'b0;
    else if (fall) spi_miso <= txreg[3'd7 - bitcnt];
  end
endmodule

// File: rtl/fram_spi_slave_chk.sv
module fram_spi_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic spi_miso,
  input logic sck_s,
  input logic cs_s,
  input logic cs_rise,
  input logic wr_cmd,
  input logic wel,
  input logic srwd,
  input logic [2:0] bp,
  input logic wp_s,
  input logic skip_st,
  input logic data_adv,
  input logic [ADDR_W-1:0] addr
);
  // R12
  miso_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_s && !$past(cs_s) && sck_s && $past(sck_s)) |-> $stable(spi_miso));

  // R6
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && wr_cmd) |=> !wel);

  // R5
  stat_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> $stable({srwd, bp}));

  // R9
  stat_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srwd && !wp_s) |=> $stable({srwd, bp}));

  // R11
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_st |-> (spi_miso == 1'b0));

  // R4
  addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_adv && addr == '1) |=> (addr == '0));
endmodule

bind fram_spi_slave fram_spi_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_miso(spi_miso), .sck_s(sck_s), .cs_s(cs_s),
  .cs_rise(cs_rise), .wr_cmd(wr_cmd), .wel(wel), .srwd(srwd), .bp(bp),
  .wp_s(wp_s), .skip_st(skip_st), .data_adv(data_adv), .addr(addr)
);

// File: tb/fram_spi_slave_test.sv
module fram_spi_slave_test;
  localparam int HALF = 8;
  localparam int MEMN = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b1;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic wp_n = 1'b1;
  logic miso;

  int checks = 0;
  int errors = 0;
  int mode_err = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [MEMN];
  logic [7:0] wbuf [MEMN];

  always #4 clk = ~clk;

  fram_spi_slave #(.MEM_BYTES(MEMN), .ADDR_BYTES(2), .CAP_CODE(8'h21), .PART_CODE(8'h08)) uut (
    .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n),
    .spi_mosi(mosi), .spi_wp_n(wp_n), .spi_miso(miso)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic desel();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sck = 1'b0;
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      if (miso !== rx[i]) mode_err++;
    end
  endtask

  task automatic op1(input logic [7:0] op);
    logic [7:0] r;
    sel();
    xfer(op, r);
    desel();
  endtask

  task automatic wrsr(input logic [7:0] v);
    logic [7:0] r;
    sel();
    xfer(8'h01, r);
    xfer(v, r);
    desel();
  endtask

  task automatic get_status(output logic [7:0] s);
    logic [7:0] r;
    sel();
    xfer(8'h05, r);
    xfer(8'h00, s);
    desel();
  endtask

  function automatic bit prot_m(input int code, input int a);
    if (code == 0) return 1'b0;
    if (code == 7) return 1'b1;
    return a >= MEMN - (MEMN >> (7 - code));
  endfunction

  task automatic wr_burst(input int a, input int n, input bit en, input int code);
    logic [7:0] r;
    sel();
    xfer(8'h02, r);
    xfer(8'((a >> 8) & 255), r);
    xfer(8'(a & 255), r);
    for (int k = 0; k < n; k++) begin
      xfer(wbuf[k], r);
      if (en && !prot_m(code, (a + k) % MEMN)) exp_mem[(a + k) % MEMN] = wbuf[k];
    end
    desel();
  endtask

  task automatic rd_burst(input int a, input int n, input string req);
    logic [7:0] r;
    sel();
    xfer(8'h03, r);
    xfer(8'((a >> 8) & 255), r);
    xfer(8'(a & 255), r);
    for (int k = 0; k < n; k++) begin
      xfer(8'h00, r);
      chk(req, r, exp_mem[(a + k) % MEMN]);
    end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, r;
    for (int i = 0; i < MEMN; i++) exp_mem[i] = 8'h00;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1: reset state
    chk("R1 idle output", {7'd0, miso}, 8'h00);
    get_status(s);
    chk("R1 status", s, 8'h00);
    rd_burst(0, 4, "R1 array");

    // R2: latch set and clear
    op1(8'h06);
    get_status(s);
    chk("R2 set", s, 8'h02);

    // R3: repeated status slots
    sel();
    xfer(8'h05, r);
    for (int k = 0; k < 3; k++) begin
      xfer(8'h00, r);
      chk("R3 repeat", r, 8'h02);
    end
    desel();
    op1(8'h04);
    get_status(s);
    chk("R2 clear", s, 8'h00);

    // R5: unarmed writes
    wbuf[0] = 8'h5A;
    wbuf[1] = 8'hA5;
    wr_burst(8'h40, 2, 1'b0, 0);
    rd_burst(8'h40, 2, "R5 data");
    wrsr(8'h0C);
    get_status(s);
    chk("R5 status", s, 8'h00);

    // R4: full sweep
    for (int k = 0; k < MEMN; k++) wbuf[k] = 8'((k * 7 + 3) & 255);
    op1(8'h06);
    wr_burst(0, MEMN, 1'b1, 0);
    get_status(s);
    chk("R6 after write", s, 8'h00);
    rd_burst(0, MEMN, "R4 sweep");

    // R4: wrap at top
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB; wbuf[2] = 8'hCC;
    op1(8'h06);
    wr_burst(8'hFF, 3, 1'b1, 0);
    rd_burst(8'hFE, 4, "R4 wrap");

    // R5: second write without rearming
    wbuf[0] = 8'h11;
    wr_burst(8'h10, 1, 1'b0, 0);
    rd_burst(8'h10, 1, "R6 no rearm");

    // R7: every protect code across its boundary
    for (int c = 0; c < 8; c++) begin
      int b;
      op1(8'h06);
      wrsr(8'(c << 2));
      get_status(s);
      chk("R8 code load", s, 8'(c << 2));
      b = (c == 7) ? 0 : MEMN - (MEMN >> (7 - c));
      if (c == 0) b = MEMN;
      for (int k = 0; k < 4; k++) wbuf[k] = 8'(8'hC0 + c * 4 + k);
      op1(8'h06);
      wr_burst((b - 2 + MEMN) % MEMN, 4, 1'b1, c);
      rd_burst((b - 2 + MEMN) % MEMN, 4, "R7 guard");
    end
    op1(8'h06);
    wrsr(8'h00);

    // R8: only bits 7 and 4:2 load
    op1(8'h06);
    wrsr(8'hFF);
    get_status(s);
    chk("R8 mask", s, 8'h9C);

    // R9: pin lock
    wp_n = 1'b0;
    op1(8'h06);
    wrsr(8'h00);
    get_status(s);
    chk("R9 locked", s, 8'h9C);
    wp_n = 1'b1;
    op1(8'h06);
    wrsr(8'h00);
    get_status(s);
    chk("R9 unlocked", s, 8'h00);
    wp_n = 1'b0;
    op1(8'h06);
    wrsr(8'h08);
    get_status(s);
    chk("R9 no lock bit", s, 8'h08);
    op1(8'h06);
    wrsr(8'h00);
    get_status(s);
    chk("R9 no lock bit clear", s, 8'h00);
    wp_n = 1'b1;

    // R10: identification
    sel();
    xfer(8'h9F, r);
    for (int k = 0; k < 9; k++) begin
      xfer(8'h00, r);
      chk("R10 id", r, (k < 6) ? 8'h7F : (k == 6) ? 8'hC2 : (k == 7) ? 8'h21 : 8'h08);
    end
    desel();

    // R11: unknown opcode
    sel();
    xfer(8'hAB, r);
    chk("R11 opcode slot", r, 8'h00);
    xfer(8'h06, r);
    chk("R11 slot", r, 8'h00);
    xfer(8'h05, r);
    chk("R11 slot", r, 8'h00);
    desel();
    get_status(s);
    chk("R11 no effect", s, 8'h00);

    // R13: partial byte dropped
    sel();
    for (int i = 0; i < 4; i++) begin
      sck = 1'b0; mosi = 1'b1; wait_clk(HALF);
      sck = 1'b1; wait_clk(HALF);
    end
    desel();
    op1(8'h06);
    get_status(s);
    chk("R13 reframe", s, 8'h02);
    op1(8'h04);

    // R12: output stable through high phase
    chk("R12 mode3", 8'(mode_err), 8'h00);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule